// File: doc/BRIEF.md
# Modulation LFO Waveform Generator

This block is the low-frequency oscillator of a single voice in a sample-playback sound engine. A 16-bit phase accumulator with 8 fractional bits moves forward once per audio sample strobe. The step size comes from a 32-entry rate table, and the upper byte of the phase indexes a 256-point waveform. From that one phase the block forms two views. The first is an unsigned value meant for amplitude (tremolo) modulation. The second is a signed value meant for pitch (vibrato) modulation. Four shapes are available: sawtooth, square, triangle and noise. Each shape is defined separately for the two views. A depth select then scales each raw value into a modulation word, given in attenuation or pitch units.

The voice logic clears the phase at key-on and pulses the strobe at the 44.1 kHz output rate. It applies the two modulation words to its own volume and pitch paths. The noise source is a free-running shift register. It is captured into a byte only when the waveform index moves, so the noise value stays fixed for each index.

Top module: `lfo_wavegen`

## Requirements
- R1: After reset the phase is 0. On each cycle with `smp_en` high and `phase_clr` low, the phase grows by the selected step, modulo 65536. On a cycle with both low, the phase is unchanged. The waveform index is phase bits 15:8.
- R2: `phase_clr` clears the phase to 0 at the next clock edge, and it takes priority over `smp_en`.
- R3: The step for rate select r is round(F[r] × 65536 / 44100). F rises over 32 values: 0.17, 0.19, 0.23, 0.27, 0.34, 0.39, 0.45, 0.55, 0.68, 0.78, 0.92, 1.10, 1.39, 1.60, 1.87, 2.27, 2.87, 3.31, 3.92, 4.79, 6.15, 7.18, 8.60, 10.8, 14.4, 17.2, 21.5, 28.7, 43.1, 57.4, 86.1 and 172.3 Hz.
- R4: `wave_sel` = 0 selects the sawtooth. `am_raw` is 255−i. `pm_raw` is i for i<128 and i−256 otherwise.
- R5: `wave_sel` = 1 selects the square. `am_raw` is 255 for i<128 and 0 otherwise. `pm_raw` is +127 for i<128 and −128 otherwise.
- R6: `wave_sel` = 2 selects the triangle. `am_raw` is 255−2i for i<128 and 2i−256 otherwise.
- R7: With `wave_sel` = 2, `pm_raw` is 2i below 64, 255−2i below 128, 256−2i below 192, and 2i−511 from 192 up.
- R8: `wave_sel` = 3 selects noise. `pm_raw` equals 128 − `am_raw`. The noise byte changes only when the index changes, and it does change over a sweep of indices.
- R9: `am_mod` = floor(`am_raw` × A[d] / 256), with A = {0,4,8,15,30,60,120,240} for `depth_sel` d = 0..7. The unit is 0.1 dB of attenuation, so full scale at d=7 is 24 dB.
- R10: `pm_mod` = floor(`pm_raw` × P[d] / 128), with P = {0,14,27,54,110,224,460,988}. The unit is half-cents, so full scale at d=7 is about 494 cents.
- R11: With `depth_sel` = 0, both `am_mod` and `pm_mod` are 0 for every shape and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; advances the phase |
| phase_clr | input | 1 | Synchronous phase clear (key-on) |
| rate_sel | input | 5 | Rate table select |
| wave_sel | input | 2 | Shape: 0 saw, 1 square, 2 triangle, 3 noise |
| depth_sel | input | 3 | Depth level, 0 = none |
| am_raw | output | 8 | Unsigned amplitude waveform value |
| pm_raw | output | 9 | Signed pitch waveform value |
| am_mod | output | 8 | Scaled attenuation, 0.1 dB units |
| pm_mod | output | 11 | Signed scaled pitch offset, half-cent units |

## Verification
The outputs are combinational functions of the phase and the latched noise byte. A wrong phase therefore shows up at `am_raw` on the same cycle after the faulty strobe, because with the sawtooth selected `am_raw` is 255 minus the index. A wrong step entry builds up over many strobes, so each rate is run for hundreds of strobes, which makes small step errors reach the index. A noise byte that changes while the index holds shows up as a changed `am_raw` on a strobe that did not move the index.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

   localparam int RATE_W  = 5;
   localparam int STEP_W  = 9;
   localparam int DEPTH_W = 3;

   typedef enum logic [1:0] {
      SHP_SAW   = 2'd0,
      SHP_SQR   = 2'd1,
      SHP_TRI   = 2'd2,
      SHP_NOISE = 2'd3
   } shape_e;

   // phase increment per strobe, 8.8 fixed point, nearest-integer rounded
   function automatic logic [STEP_W-1:0] rate_step(input logic [RATE_W-1:0] r);
      logic [STEP_W-1:0] s;
      case (r)
         5'd0, 5'd1, 5'd2, 5'd3:                   s = 9'd0;
         5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10: s = 9'd1;
         5'd11, 5'd12, 5'd13:                       s = 9'd2;
         5'd14, 5'd15:                              s = 9'd3;
         5'd16: s = 9'd4;
         5'd17: s = 9'd5;
         5'd18: s = 9'd6;
         5'd19: s = 9'd7;
         5'd20: s = 9'd9;
         5'd21: s = 9'd11;
         5'd22: s = 9'd13;
         5'd23: s = 9'd16;
         5'd24: s = 9'd21;
         5'd25: s = 9'd26;
         5'd26: s = 9'd32;
         5'd27: s = 9'd43;
         5'd28: s = 9'd64;
         5'd29: s = 9'd85;
         5'd30: s = 9'd128;
         default: s = 9'd256;
      endcase
      return s;
   endfunction

   // attenuation span at full scale, 0.1 dB units
   function automatic logic [7:0] am_span(input logic [DEPTH_W-1:0] d);
      case (d)
         3'd0: return 8'd0;
         3'd1: return 8'd4;
         3'd2: return 8'd8;
         3'd3: return 8'd15;
         3'd4: return 8'd30;
         3'd5: return 8'd60;
         3'd6: return 8'd120;
         default: return 8'd240;
      endcase
   endfunction

   // pitch span at full scale, half-cent units
   function automatic logic [10:0] pm_span(input logic [DEPTH_W-1:0] d);
      case (d)
         3'd0: return 11'd0;
         3'd1: return 11'd14;
         3'd2: return 11'd27;
         3'd3: return 11'd54;
         3'd4: return 11'd110;
         3'd5: return 11'd224;
         3'd6: return 11'd460;
         default: return 11'd988;
      endcase
   endfunction

endpackage

// File: rtl/lfo_phase.sv
module lfo_phase #(
   parameter int PHASE_W = 16,
   parameter int FRAC_W  = 8,
   parameter int STEP_W  = 9,
   localparam int IDX_W  = PHASE_W - FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_en,
   input  logic               phase_clr,
   input  logic [STEP_W-1:0]  step,
   output logic [PHASE_W-1:0] phase_q,
   output logic               idx_chg
);

   logic [PHASE_W-1:0] phase_d;

   always_comb begin
      if (phase_clr)
         phase_d = '0;
      else if (smp_en)
         phase_d = phase_q + PHASE_W'(step);
      else
         phase_d = phase_q;
   end

   assign idx_chg = (phase_d[PHASE_W-1 -: IDX_W] != phase_q[PHASE_W-1 -: IDX_W]);

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase_q <= '0;
      else
         phase_q <= phase_d;
   end

endmodule

// File: rtl/lfo_noise.sv
module lfo_noise #(
   parameter int LFSR_W = 16,
   parameter int OUT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   output logic [OUT_W-1:0] noise_q
);

   logic [LFSR_W-1:0] sr_q;
   logic              fb;

   generate
      if (LFSR_W == 16) begin : g_taps16
         assign fb = sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10];
      end else if (LFSR_W == 12) begin : g_taps12
         assign fb = sr_q[11] ^ sr_q[10] ^ sr_q[9] ^ sr_q[3];
      end else if (LFSR_W == 8) begin : g_taps8
         assign fb = sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3];
      end else begin : g_taps_bad
         assign fb = 1'b0;
         $error("lfo_noise: LFSR_W must be 8, 12 or 16");
      end
      if (OUT_W > LFSR_W) begin : g_w_bad
         $error("lfo_noise: OUT_W exceeds LFSR_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q    <= LFSR_W'(1);
         noise_q <= '0;
      end else begin
         sr_q <= {sr_q[LFSR_W-2:0], fb};
         if (capture)
            noise_q <= sr_q[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/lfo_shape.sv
module lfo_shape
   import lfo_pkg::*;
(
   input  logic [7:0]        idx,
   input  logic [1:0]        wave_sel,
   input  logic [7:0]        noise,
   output logic [7:0]        am_raw,
   output logic signed [8:0] pm_raw
);

   logic signed [10:0] i_s;
   logic signed [10:0] n_s;
   logic signed [10:0] pm_w;

   assign i_s = signed'({3'b000, idx});
   assign n_s = signed'({3'b000, noise});

   always_comb begin
      case (shape_e'(wave_sel))
         SHP_SAW: begin
            am_raw = 8'd255 - idx;
            pm_w   = idx[7] ? (i_s - 11'sd256) : i_s;
         end
         SHP_SQR: begin
            am_raw = idx[7] ? 8'd0 : 8'd255;
            pm_w   = idx[7] ? -11'sd128 : 11'sd127;
         end
         SHP_TRI: begin
            am_raw = idx[7] ? {idx[6:0], 1'b0} : (8'd255 - {idx[6:0], 1'b0});
            case (idx[7:6])
               2'd0:    pm_w = 11'sd2 * i_s;
               2'd1:    pm_w = 11'sd255 - 11'sd2 * i_s;
               2'd2:    pm_w = 11'sd256 - 11'sd2 * i_s;
               default: pm_w = 11'sd2 * i_s - 11'sd511;
            endcase
         end
         default: begin
            am_raw = noise;
            pm_w   = 11'sd128 - n_s;
         end
      endcase
   end

   assign pm_raw = pm_w[8:0];

endmodule

// File: rtl/lfo_depth.sv
module lfo_depth
   import lfo_pkg::*;
(
   input  logic [2:0]         depth_sel,
   input  logic [7:0]         am_raw,
   input  logic signed [8:0]  pm_raw,
   output logic [7:0]         am_mod,
   output logic signed [10:0] pm_mod
);

   logic [15:0]        am_prod;
   logic signed [20:0] pm_prod;
   logic signed [11:0] pm_k;

   assign pm_k    = signed'({1'b0, pm_span(depth_sel)});
   assign am_prod = am_raw * am_span(depth_sel);
   assign pm_prod = 21'(pm_raw) * 21'(pm_k);
   assign am_mod  = am_prod[15:8];
   assign pm_mod  = pm_prod[17:7];

endmodule

// File: rtl/lfo_wavegen.sv
module lfo_wavegen
   import lfo_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int FRAC_W  = 8,
   parameter int LFSR_W  = 16,
   localparam int IDX_W  = PHASE_W - FRAC_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_en,
   input  logic                phase_clr,
   input  logic [4:0]          rate_sel,
   input  logic [1:0]          wave_sel,
   input  logic [2:0]          depth_sel,
   output logic [7:0]          am_raw,
   output logic signed [8:0]   pm_raw,
   output logic [7:0]          am_mod,
   output logic signed [10:0]  pm_mod
);

   generate
      if (IDX_W != 8) begin : g_idx_bad
         $error("lfo_wavegen: waveform index must be 8 bits");
      end
      if (FRAC_W != 8) begin : g_frac_bad
         $error("lfo_wavegen: step table assumes 8 fractional bits");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic               idx_chg;
   logic [7:0]         noise_q;
   logic [STEP_W-1:0]  step;

   assign step = rate_step(rate_sel);

   lfo_phase #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en   (smp_en),
      .phase_clr(phase_clr),
      .step     (step),
      .phase_q  (phase_q),
      .idx_chg  (idx_chg)
   );

   lfo_noise #(.LFSR_W(LFSR_W), .OUT_W(8)) u_noise (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(idx_chg),
      .noise_q(noise_q)
   );

   lfo_shape u_shape (
      .idx     (phase_q[PHASE_W-1 -: IDX_W]),
      .wave_sel(wave_sel),
      .noise   (noise_q),
      .am_raw  (am_raw),
      .pm_raw  (pm_raw)
   );

   lfo_depth u_depth (
      .depth_sel(depth_sel),
      .am_raw   (am_raw),
      .pm_raw   (pm_raw),
      .am_mod   (am_mod),
      .pm_mod   (pm_mod)
   );

endmodule

// File: rtl/lfo_wavegen_chk.sv
module lfo_wavegen_chk (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_en,
   input logic               phase_clr,
   input logic [1:0]         wave_sel,
   input logic [2:0]         depth_sel,
   input logic [7:0]         am_raw,
   input logic signed [8:0]  pm_raw,
   input logic [7:0]         am_mod,
   input logic signed [10:0] pm_mod,
   input logic [15:0]        phase,
   input logic [7:0]         noise
);

   // R2
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> (phase == 16'd0));

   // R1
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase_clr && !smp_en) |=> $stable(phase));

   // R8
   noise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[15:8] == $past(phase[15:8])) |-> (noise == $past(noise)));

   // R8
   noise_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_sel == 2'd3) |-> (10'(signed'(pm_raw)) == 10'sd128 - signed'({2'b00, am_raw})));

   // R5
   square_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_sel == 2'd1) |-> (am_raw == 8'd0 || am_raw == 8'd255));

   // R11
   no_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_sel == 3'd0) |-> (am_mod == 8'd0 && pm_mod == 11'sd0));

endmodule

bind lfo_wavegen lfo_wavegen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_en   (smp_en),
   .phase_clr(phase_clr),
   .wave_sel (wave_sel),
   .depth_sel(depth_sel),
   .am_raw   (am_raw),
   .pm_raw   (pm_raw),
   .am_mod   (am_mod),
   .pm_mod   (pm_mod),
   .phase    (phase_q),
   .noise    (noise_q)
);

// File: tb/test_lfo_wavegen.sv
module test_lfo_wavegen;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_en = 1'b0;
   logic               phase_clr = 1'b0;
   logic [4:0]         rate_sel = '0;
   logic [1:0]         wave_sel = '0;
   logic [2:0]         depth_sel = '0;
   logic [7:0]         am_raw;
   logic signed [8:0]  pm_raw;
   logic [7:0]         am_mod;
   logic signed [10:0] pm_mod;

   int errors = 0;
   int checks = 0;
   int acc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lfo_wavegen i_lfo_wavegen (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .phase_clr(phase_clr),
      .rate_sel(rate_sel), .wave_sel(wave_sel), .depth_sel(depth_sel),
      .am_raw(am_raw), .pm_raw(pm_raw), .am_mod(am_mod), .pm_mod(pm_mod)
   );

   real freq [32] = '{0.17, 0.19, 0.23, 0.27, 0.34, 0.39, 0.45, 0.55,
                      0.68, 0.78, 0.92, 1.10, 1.39, 1.60, 1.87, 2.27,
                      2.87, 3.31, 3.92, 4.79, 6.15, 7.18, 8.60, 10.8,
                      14.4, 17.2, 21.5, 28.7, 43.1, 57.4, 86.1, 172.3};
   int aspan [8] = '{0, 4, 8, 15, 30, 60, 120, 240};
   int pspan [8] = '{0, 14, 27, 54, 110, 224, 460, 988};

   function automatic int step_of(int r);
      return $rtoi(freq[r] * 65536.0 / 44100.0 + 0.5);
   endfunction

   function automatic int exp_am(int w, int i);
      case (w)
         0: return 255 - i;
         1: return (i < 128) ? 255 : 0;
         default: return (i < 128) ? 255 - 2 * i : 2 * i - 256;
      endcase
   endfunction

   function automatic int exp_pm(int w, int i);
      case (w)
         0: return (i < 128) ? i : i - 256;
         1: return (i < 128) ? 127 : -128;
         default: begin
            if (i < 64) return 2 * i;
            else if (i < 128) return 255 - 2 * i;
            else if (i < 192) return 256 - 2 * i;
            else return 2 * i - 511;
         end
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic strobe(bit en, bit clr, int r);
      @(negedge clk);
      smp_en    = en;
      phase_clr = clr;
      rate_sel  = 5'(r);
      @(negedge clk);
      smp_en    = 1'b0;
      phase_clr = 1'b0;
      if (clr) acc = 0;
      else if (en) acc = (acc + step_of(r)) % 65536;
   endtask

   function automatic int idx();
      return (acc >> 8) & 255;
   endfunction

   task automatic check_mods(string ra, string rp);
      int a = int'(am_raw);
      int p = int'(pm_raw);
      int d = int'(depth_sel);
      check(ra, int'(am_mod), (a * aspan[d]) >>> 8);
      check(rp, int'(pm_mod), (p * pspan[d]) >>> 7);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int prev_noise;
      int changes;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state: sawtooth am = 255 - 0
      check("R1 reset", int'(am_raw), 255);
      check("R11 reset mod", int'(am_mod), 0);

      // R3 every rate entry, with wrap at the fast end (R1)
      for (int r = 0; r < 32; r++) begin
         strobe(1'b0, 1'b1, r);
         for (int k = 1; k <= 300; k++) begin
            strobe(1'b1, 1'b0, r);
            if (k % 50 == 0) check($sformatf("R3 rate %0d", r), int'(am_raw), 255 - idx());
         end
      end

      // R1 hold with no strobe
      strobe(1'b0, 1'b1, 31);
      for (int k = 0; k < 5; k++) strobe(1'b1, 1'b0, 31);
      for (int k = 0; k < 4; k++) begin
         strobe(1'b0, 1'b0, 31);
         check("R1 hold", int'(am_raw), 255 - idx());
      end

      // R2 clear wins over strobe
      strobe(1'b1, 1'b1, 31);
      check("R2 clear priority", int'(am_raw), 255);

      // R4..R7, R9..R11: full index sweep per shape, step 256
      for (int w = 0; w < 3; w++) begin
         wave_sel = 2'(w);
         strobe(1'b0, 1'b1, 31);
         for (int n = 0; n < 256; n++) begin
            depth_sel = 3'(n % 8);
            #1;
            check(w == 0 ? "R4 am" : (w == 1 ? "R5 am" : "R6 am"), int'(am_raw), exp_am(w, idx()));
            check(w == 0 ? "R4 pm" : (w == 1 ? "R5 pm" : "R7 pm"), int'(pm_raw), exp_pm(w, idx()));
            if (n % 8 == 0) begin
               check("R11 am zero", int'(am_mod), 0);
               check("R11 pm zero", int'(pm_mod), 0);
            end else
               check_mods("R9 am depth", "R10 pm depth");
            strobe(1'b1, 1'b0, 31);
         end
      end

      // R8 noise at step 256: offset relation and variation
      wave_sel  = 2'd3;
      depth_sel = 3'd7;
      strobe(1'b0, 1'b1, 31);
      prev_noise = int'(am_raw);
      changes = 0;
      for (int n = 0; n < 256; n++) begin
         strobe(1'b1, 1'b0, 31);
         check("R8 pm offset", int'(pm_raw), 128 - int'(am_raw));
         check_mods("R9 noise am", "R10 noise pm");
         if (int'(am_raw) != prev_noise) changes++;
         prev_noise = int'(am_raw);
      end
      check("R8 noise varies", (changes >= 128) ? 1 : 0, 1);

      // R8 noise held while index constant (step 1)
      strobe(1'b0, 1'b1, 4);
      prev_noise = int'(am_raw);
      for (int n = 0; n < 300; n++) begin
         int old_idx = idx();
         strobe(1'b1, 1'b0, 4);
         if (idx() == old_idx) check("R8 noise hold", int'(am_raw), prev_noise);
         prev_noise = int'(am_raw);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule